// File: doc/BRIEF.md
# Event-Driven Status Message Retransmission Scheduler

This block decides the instants at which a publisher puts its status message on the wire. While the status word stays the same, the block emits a keep-alive copy once per heartbeat period. When any bit of the status word changes, the block emits a copy at once. It then repeats that copy with gaps that start short and double each time. Once a doubled gap would reach or exceed the heartbeat period, the gap is capped there. This gets a fresh status to subscribers within a few milliseconds and keeps link traffic low once things are quiet. Encoding the frame and driving the network are left to the consumer of the send strobe.

Time is counted in a 1 ms tick supplied from outside. Each emitted copy carries a snapshot of the status word, a state number that counts status changes, and a sequence number. The sequence number is zero on the copy that announces a change and rises by one on each later copy. A downstream ready input can hold a send back. A held send stays pending until ready returns and is never lost. If the status changes while a send is pending, the pending send is replaced by the newer message.

Top module: `evt_retx_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `state_num`, `seq_num` and `send_status` to zero and schedules no send. After reset is released with a steady status word, the first send comes HEARTBEAT_MS (default 100) ticks later.
- R2: While the status word is unchanged and `tx_ready` is high, `send_pulse` fires once every HEARTBEAT_MS ticks.
- R3: A status word that differs from `send_status` in cycle c is copied into `send_status` at the edge ending cycle c. `send_pulse` is high in cycle c+1 if `tx_ready` is high.
- R4: Counting from the change, the gaps between successive sends are FIRST_MS, 2·FIRST_MS, 4·FIRST_MS and so on, for BURST_STEPS gaps (defaults 4, 8, 16, 32, 64 ticks). Each gap is capped at HEARTBEAT_MS, and every gap after those is HEARTBEAT_MS.
- R5: `state_num` rises by exactly one (modulo 2^STN_W) at each status change and holds its value otherwise. `send_status` likewise holds its value when no change occurs.
- R6: The copy sent first after a change carries `seq_num` 0. Each send that is not superseded by a change in the same cycle advances `seq_num` by one for the next copy.
- R7: A change that occurs while a repeat burst is in progress restarts the gap sequence at FIRST_MS from that change.
- R8: `send_pulse` is high only in cycles where `tx_ready` is high. A send that is due while `tx_ready` is low waits until `tx_ready` is high.
- R9: The gap timer keeps running while a send waits. Any number of timer expiries that fall inside one wait produce a single send.
- R10: If a change arrives in the same cycle that a pending send is taken, that send still carries the previous snapshot and sequence number. The new status is sent in the next ready cycle with `seq_num` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| status_in | input | STATUS_W | Live status word to publish |
| tx_ready | input | 1 | Downstream can take a message this cycle |
| send_pulse | output | 1 | One-cycle strobe: send a message now |
| send_status | output | STATUS_W | Status snapshot carried by the message |
| state_num | output | STN_W | Count of status changes |
| seq_num | output | SEQ_W | Copy number since the last change |

## Verification
The bound checker watches properties that relate one cycle to the next, on every cycle. A strobe never appears without ready. A change advances the state number by one, moves the snapshot and zeroes the sequence number. A quiet cycle leaves state and snapshot untouched. A send taken without a change advances the sequence number. Properties cannot express the timing of the gaps in ticks, the restart of the burst on a mid-burst change, or the merging of several expiries during a long ready stall into one send. Those behaviours appear only in the bench scenarios, where a tick-level reference model and logs of send instants expose them.

// File: rtl/retx_pkg.sv
// Package retx_pkg
// Shared helper for the retransmission scheduler: the gap length in ticks
// for a given position in the repeat burst.
// Assumes first >= 1 and hb >= first.
package retx_pkg;

    // Gap for burst position idx: first doubled idx times, capped at hb.
    function automatic int unsigned burst_gap(input int unsigned idx,
                                              input int unsigned first,
                                              input int unsigned steps,
                                              input int unsigned hb);
        int unsigned g;
        if (idx >= steps) begin
            return hb;
        end
        g = first << idx;
        return (g > hb) ? hb : g;
    endfunction

endpackage

// File: rtl/retx_change_track.sv
// Module retx_change_track
// Holds the published snapshot of the status word and the change counter.
// Flags a change whenever the live word differs from the snapshot, and takes
// the new word and advances the counter at the same edge.
// Assumes status_in is synchronous to clk.
module retx_change_track #(
    parameter int STATUS_W = 16,
    parameter int STN_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [STATUS_W-1:0] status_in,
    output logic                change,
    output logic [STATUS_W-1:0] snapshot,
    output logic [STN_W-1:0]    state_num
);

    // Compare the live word against the published snapshot.
    always_comb begin
        change = (status_in != snapshot);
    end

    // Capture a new snapshot and count the change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snapshot  <= '0;
            state_num <= '0;
        end else if (change) begin
            snapshot  <= status_in;
            state_num <= state_num + 1'b1;
        end
    end

endmodule

// File: rtl/retx_interval_timer.sv
// Module retx_interval_timer
// Counts millisecond ticks within the current gap and raises 'due' on the
// tick that completes the gap, then moves to the next, longer gap. A restart
// (status change) returns to the first gap with the count cleared.
// Assumes tick is a single-cycle pulse and restart wins over tick.
module retx_interval_timer
    import retx_pkg::*;
#(
    parameter int FIRST_MS     = 4,
    parameter int BURST_STEPS  = 5,
    parameter int HEARTBEAT_MS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic due
);

    localparam int STEP_W  = $clog2(BURST_STEPS + 1);
    localparam int N_SLOTS = 1 << STEP_W;
    localparam int CNT_W   = $clog2(HEARTBEAT_MS + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(BURST_STEPS);

    logic [CNT_W-1:0]  gap_tab [N_SLOTS];
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  elapsed;
    logic [CNT_W-1:0]  gap_now;
    logic              hit;

    // One constant gap per burst position; unused slots hold the heartbeat.
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_gap
        assign gap_tab[k] = CNT_W'(burst_gap(k, FIRST_MS, BURST_STEPS, HEARTBEAT_MS));
    end

    // Select the active gap and detect the tick that closes it.
    always_comb begin
        gap_now = gap_tab[step];
        hit     = tick && (elapsed == gap_now - 1'b1);
        due     = hit && !restart;
    end

    // Advance the tick count and the burst position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step    <= LAST_STEP;
            elapsed <= '0;
        end else if (restart) begin
            step    <= '0;
            elapsed <= '0;
        end else if (tick) begin
            if (hit) begin
                elapsed <= '0;
                step    <= (step == LAST_STEP) ? step : step + 1'b1;
            end else begin
                elapsed <= elapsed + 1'b1;
            end
        end
    end

endmodule

// File: rtl/retx_send_gate.sv
// Module retx_send_gate
// Keeps one pending-send flag, releases it as a one-cycle strobe when the
// downstream is ready, and numbers the copies sent since the last change.
// Assumes change and due arrive as single-cycle requests; requests landing
// while a send is pending merge into that send.
module retx_send_gate #(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             change,
    input  logic             due,
    input  logic             tx_ready,
    output logic             send_pulse,
    output logic [SEQ_W-1:0] seq_num
);

    logic pending;

    // Strobe only while a send is pending and the downstream can take it.
    always_comb begin
        send_pulse = pending && tx_ready;
    end

    // Track the pending request and the copy number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            seq_num <= '0;
        end else begin
            pending <= change || due || (pending && !tx_ready);
            if (change) begin
                seq_num <= '0;
            end else if (send_pulse) begin
                seq_num <= seq_num + 1'b1;
            end
        end
    end

endmodule

// File: rtl/evt_retx_sched.sv
// Module evt_retx_sched (top)
// Schedules publications of a status word: a keep-alive every heartbeat,
// an immediate send on change, then repeats with doubling gaps up to the
// heartbeat. Gaps are counted in external millisecond ticks.
// Assumes all inputs are synchronous to clk.
module evt_retx_sched #(
    parameter int STATUS_W     = 16,
    parameter int STN_W        = 16,
    parameter int SEQ_W        = 16,
    parameter int FIRST_MS     = 4,
    parameter int BURST_STEPS  = 5,
    parameter int HEARTBEAT_MS = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_ms,
    input  logic [STATUS_W-1:0] status_in,
    input  logic                tx_ready,
    output logic                send_pulse,
    output logic [STATUS_W-1:0] send_status,
    output logic [STN_W-1:0]    state_num,
    output logic [SEQ_W-1:0]    seq_num
);

    logic change;
    logic due;

    retx_change_track #(
        .STATUS_W (STATUS_W),
        .STN_W    (STN_W)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_in (status_in),
        .change    (change),
        .snapshot  (send_status),
        .state_num (state_num)
    );

    retx_interval_timer #(
        .FIRST_MS     (FIRST_MS),
        .BURST_STEPS  (BURST_STEPS),
        .HEARTBEAT_MS (HEARTBEAT_MS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_ms),
        .restart (change),
        .due     (due)
    );

    retx_send_gate #(
        .SEQ_W (SEQ_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .change     (change),
        .due        (due),
        .tx_ready   (tx_ready),
        .send_pulse (send_pulse),
        .seq_num    (seq_num)
    );

endmodule

// File: rtl/retx_sched_checks.sv
// Module retx_sched_checks
// Cycle-to-cycle properties of the scheduler's ports, bound to the top.
// Assumes the same parameters as the instance it is bound to.
module retx_sched_checks #(
    parameter int STATUS_W = 16,
    parameter int STN_W    = 16,
    parameter int SEQ_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [STATUS_W-1:0] status_in,
    input logic                tx_ready,
    input logic                send_pulse,
    input logic [STATUS_W-1:0] send_status,
    input logic [STN_W-1:0]    state_num,
    input logic [SEQ_W-1:0]    seq_num
);

    // Reset clears the counters and leaves nothing to send.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (state_num == '0 && seq_num == '0 && send_status == '0 && !send_pulse));

    // A strobe needs the downstream ready.
    assert_strobe_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        send_pulse |-> tx_ready);

    // A change moves the live word into the snapshot.
    assert_change_snapshot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_in != send_status) |=> (send_status == $past(status_in)));

    // A change advances the state number by one.
    assert_change_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_in != send_status) |=> (state_num == STN_W'($past(state_num) + 1'b1)));

    // Without a change, state and snapshot hold.
    assert_quiet_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status_in == send_status) |=> ($stable(state_num) && $stable(send_status)));

    // A change zeroes the copy number.
    assert_change_zero_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status_in != send_status) |=> (seq_num == '0));

    // A send without a change advances the copy number.
    assert_send_advances_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (send_pulse && status_in == send_status) |=> (seq_num == SEQ_W'($past(seq_num) + 1'b1)));

endmodule

bind evt_retx_sched retx_sched_checks #(
    .STATUS_W (STATUS_W),
    .STN_W    (STN_W),
    .SEQ_W    (SEQ_W)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_in   (status_in),
    .tx_ready    (tx_ready),
    .send_pulse  (send_pulse),
    .send_status (send_status),
    .state_num   (state_num),
    .seq_num     (seq_num)
);

// File: tb/tb_evt_retx_sched.sv
// Bench for evt_retx_sched: a tick-level behavioural model compared every
// cycle, plus directed scenarios on send instants and stalls.
`timescale 1ns/1ps
module tb_evt_retx_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic [15:0] status_in = '0;
    logic        tx_ready = 1'b1;
    logic        send_pulse;
    logic [15:0] send_status;
    logic [15:0] state_num;
    logic [15:0] seq_num;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_total = 0;
    int pulse_cnt = 0;
    int pulse_ticks[$];
    int tick_div = 0;

    // Reference model state.
    logic [15:0] m_snap;
    int m_st, m_seq, m_t, m_next, m_g;
    bit m_pend;

    evt_retx_sched dut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .status_in(status_in),
        .tx_ready(tx_ready), .send_pulse(send_pulse), .send_status(send_status),
        .state_num(state_num), .seq_num(seq_num)
    );

    always #10 clk = ~clk;

    function automatic int gapf(input int g);
        int v;
        if (g >= 5) return 100;
        v = 4 * (1 << g);
        return (v > 100) ? 100 : v;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Millisecond tick: one cycle in five.
    always @(negedge clk) begin
        tick_div = (tick_div == 4) ? 0 : tick_div + 1;
        tick_ms <= (tick_div == 4);
    end

    // Every cycle: compare against the model, then advance it past the edge.
    always @(negedge clk) begin
        bit exp_pulse, chg, due;
        #5;
        cycles++;
        if (!rst_n) begin
            m_snap = '0; m_st = 0; m_seq = 0; m_pend = 0;
            m_t = 0; m_g = 5; m_next = 100;
        end else begin
            exp_pulse = m_pend && tx_ready;
            chk(send_pulse == exp_pulse, "R2/R4/R8", "send_pulse", send_pulse, exp_pulse);
            chk(send_status == m_snap, "R3", "send_status", send_status, m_snap);
            chk(state_num == m_st[15:0], "R5", "state_num", state_num, m_st & 16'hFFFF);
            chk(seq_num == m_seq[15:0], "R6", "seq_num", seq_num, m_seq & 16'hFFFF);
            if (send_pulse) begin
                pulse_cnt++;
                pulse_ticks.push_back(tick_total);
            end
            chg = (status_in != m_snap);
            due = 0;
            if (chg) begin
                m_t = 0; m_g = 0; m_next = gapf(0);
            end else if (tick_ms) begin
                m_t++;
                if (m_t == m_next) begin
                    due = 1; m_g++; m_next = m_next + gapf(m_g);
                end
            end
            if (exp_pulse) m_seq++;
            m_pend = chg || due || (m_pend && !tx_ready);
            if (chg) begin
                m_snap = status_in; m_st++; m_seq = 0;
            end
            if (tick_ms) tick_total++;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wait_ticks(input int n);
        int target;
        target = tick_total + n;
        while (tick_total < target) @(negedge clk);
    endtask

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1: reset state.
        chk(state_num == 0 && seq_num == 0 && send_status == 0 && !send_pulse,
            "R1", "reset outputs", state_num, 0);

        // R1 and R2: steady status, heartbeat sends.
        pulse_ticks.delete();
        wait_ticks(210);
        chk(pulse_ticks.size() == 2, "R2", "heartbeat count", pulse_ticks.size(), 2);
        if (pulse_ticks.size() == 2) begin
            chk(pulse_ticks[0] == 100, "R1", "first send tick", pulse_ticks[0], 100);
            chk(pulse_ticks[1] - pulse_ticks[0] == 100, "R2", "heartbeat gap",
                pulse_ticks[1] - pulse_ticks[0], 100);
        end

        // R3 and R4: change and full burst.
        @(negedge clk);
        status_in = 16'h00A5;
        pulse_ticks.delete();
        @(negedge clk); #5;
        chk(send_pulse && send_status == 16'h00A5, "R3", "immediate send", send_pulse, 1);
        chk(seq_num == 0, "R6", "seq on change", seq_num, 0);
        chk(state_num == 1, "R5", "state after change", state_num, 1);
        wait_ticks(330);
        chk(pulse_ticks.size() >= 7, "R4", "burst send count", pulse_ticks.size(), 7);
        if (pulse_ticks.size() >= 7) begin
            for (int i = 1; i < 7; i++) begin
                chk(pulse_ticks[i] - pulse_ticks[i-1] == gapf(i - 1), "R4", "burst gap",
                    pulse_ticks[i] - pulse_ticks[i-1], gapf(i - 1));
            end
        end

        // R7: change in mid-burst restarts the gaps.
        @(negedge clk);
        status_in = 16'h5A5A;
        wait_ticks(10);
        @(negedge clk);
        status_in = 16'h0F0F;
        pulse_ticks.delete();
        wait_ticks(40);
        chk(pulse_ticks.size() >= 4, "R7", "restart send count", pulse_ticks.size(), 4);
        if (pulse_ticks.size() >= 4) begin
            for (int i = 1; i < 4; i++) begin
                chk(pulse_ticks[i] - pulse_ticks[i-1] == gapf(i - 1), "R7", "restart gap",
                    pulse_ticks[i] - pulse_ticks[i-1], gapf(i - 1));
            end
        end

        // R8 and R9: long stall, expiries merge into one send.
        @(negedge clk);
        tx_ready = 1'b0;
        status_in = 16'h1111;
        p0 = pulse_cnt;
        wait_ticks(150);
        chk(pulse_cnt == p0, "R8", "sends while stalled", pulse_cnt - p0, 0);
        @(negedge clk);
        tx_ready = 1'b1;
        #5;
        chk(send_pulse && seq_num == 0 && send_status == 16'h1111, "R8", "held send released",
            send_pulse, 1);
        p0 = pulse_cnt;
        repeat (20) @(negedge clk);
        #5;
        chk(pulse_cnt - p0 == 1, "R9", "merged sends", pulse_cnt - p0, 1);

        // R10: change in the same cycle a pending send is taken.
        @(negedge clk);
        tx_ready = 1'b0;
        status_in = 16'h2222;
        repeat (3) @(negedge clk);
        tx_ready = 1'b1;
        status_in = 16'h3333;
        #5;
        chk(send_pulse && send_status == 16'h2222, "R10", "old snapshot sent", send_status, 16'h2222);
        @(negedge clk); #5;
        chk(send_pulse && send_status == 16'h3333, "R10", "new snapshot sent", send_status, 16'h3333);
        chk(seq_num == 0, "R10", "new seq", seq_num, 0);

        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule